// File: doc/BRIEF.md
# Flag-tagged double-frame interleaver

This block moves a 40-bit parallel word across a 20-bit link by sending it as two half-frames. The transmit path takes a whole word on a frame-rate strobe. It then puts the low half on the link in the next cycle and the high half in the cycle after that. A flag travels with each half and says which half it is. Each half is marked by a half-frame strobe, so the link strobe runs at twice the frame rate.

The receive path takes half-frames from a strobe that also runs at twice the frame rate. It uses the flag of each half to steer that half into place. A toggle tracks whether a low half is being held. The low half waits in a holding register until the matching high half arrives, and then both halves are presented in the same cycle with a one-cycle valid pulse. Out-of-order halves raise an error and the partial word is dropped.

All logic runs in a single clock domain. Strobe edges are modelled as clock enables.

Top module: `dfl_link`

## Requirements
- R1: While reset is held and right after it is released, `link_stb_o`, `link_flag_o`, `link_data_o`, `rx_word_o`, `rx_valid_o` and `rx_err_o` are all zero.
- R2: When `tx_load_i` is high at a clock edge and is accepted, the next cycle shows `link_stb_o`=1, `link_flag_o`=0 and `link_data_o`=word[19:0]. The cycle after that shows `link_stb_o`=1, `link_flag_o`=1 and `link_data_o`=word[39:20]. After that, `link_stb_o` returns to 0 unless a new word is loaded.
- R3: A `tx_load_i` that arrives in the cycle when the low half is on the link is ignored. The high half that follows still belongs to the earlier word.
- R4: In the receiver, a strobed half with flag 0 followed by a strobed half with flag 1 raises `rx_valid_o` for exactly one cycle, in the cycle after the flag-1 strobe. At that point `rx_word_o` = {high half, low half}. Idle cycles may lie between the two strobes.
- R5: After reset, the receiver ignores strobed flag-1 halves until it has seen a flag-0 half. While it waits, it gives no valid and no error.
- R6: Two flag-0 halves in a row give a one-cycle `rx_err_o` in the cycle after the second one. The first low half is discarded, and the second one starts the next word.
- R7: A flag-1 half that does not directly follow a flag-0 half (once synchronized) gives a one-cycle `rx_err_o` and no valid.
- R8: `rx_word_o` holds its value in every cycle in which `rx_valid_o` is low.
- R9: With the link outputs looped back to the receiver inputs, every accepted word comes out of the receiver unchanged and in order.
- R10: `rx_flag_i` and `rx_data_i` have no effect in cycles where `rx_stb_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_load_i | input | 1 | Frame strobe: accept `tx_word_i` |
| tx_word_i | input | 40 | Word to transmit |
| link_data_o | output | 20 | Half-frame on the link |
| link_flag_o | output | 1 | 0 = low half, 1 = high half |
| link_stb_o | output | 1 | Half-frame strobe |
| rx_stb_i | input | 1 | Received half-frame strobe |
| rx_flag_i | input | 1 | Received half tag |
| rx_data_i | input | 20 | Received half-frame |
| rx_word_o | output | 40 | Rebuilt word |
| rx_valid_o | output | 1 | One-cycle pulse when `rx_word_o` is new |
| rx_err_o | output | 1 | One-cycle pulse on a half-frame sequence error |

## Verification
The transmit path is tried in three ways: a lone load, a load in back-to-back frames, and a load placed on the low-half cycle. Together these separate correct half ordering from a second load wrongly overwriting the held high half. The receiver gets directed sequences that cover each case separately:
- a clean low-high pair with idle gaps between the strobes;
- leading high halves after reset;
- a doubled low half;
- a doubled high half;
- noise on the flag and data lines while the strobe is low.

Each of these changes only one aspect of the sequence, which isolates the steering, resynchronization and strobe gating. A random loopback then runs several hundred words with random data and random frame spacing. It exposes any loss, reordering or half swap against a queue of expected words.

// File: rtl/dfl_pkg.sv
package dfl_pkg;
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/dfl_tx.sv
module dfl_tx
  import dfl_pkg::*;
#(
  parameter int HALF_W = 20,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [HALF_W-1:0] data_o,
  output logic              flag_o,
  output logic              stb_o
);
  logic [HALF_W-1:0] hi_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      pend_q <= 1'b0;
      data_o <= '0;
      flag_o <= 1'b0;
      stb_o  <= 1'b0;
    end else if (pend_q) begin
      // high half owns this slot; a load here is dropped
      data_o <= hi_q;
      flag_o <= HALF_HI;
      stb_o  <= 1'b1;
      pend_q <= 1'b0;
    end else if (load_i) begin
      data_o <= word_i[HALF_W-1:0];
      hi_q   <= word_i[WORD_W-1:HALF_W];
      flag_o <= HALF_LO;
      stb_o  <= 1'b1;
      pend_q <= 1'b1;
    end else begin
      stb_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/dfl_rx.sv
module dfl_rx
  import dfl_pkg::*;
#(
  parameter int HALF_W = 20,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              flag_i,
  input  logic [HALF_W-1:0] data_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              err_o
);
  logic [HALF_W-1:0] lo_q;
  logic              lo_held_q; // derived frame toggle
  logic              synced_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q      <= '0;
      lo_held_q <= 1'b0;
      synced_q  <= 1'b0;
      word_o    <= '0;
      valid_o   <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      if (stb_i) begin
        if (half_e'(flag_i) == HALF_LO) begin
          if (lo_held_q) err_o <= 1'b1;
          lo_q      <= data_i;
          lo_held_q <= 1'b1;
          synced_q  <= 1'b1;
        end else if (lo_held_q) begin
          word_o    <= {data_i, lo_q};
          valid_o   <= 1'b1;
          lo_held_q <= 1'b0;
        end else if (synced_q) begin
          err_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dfl_link.sv
module dfl_link #(
  parameter int HALF_W = 20,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_load_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic [HALF_W-1:0] link_data_o,
  output logic              link_flag_o,
  output logic              link_stb_o,
  input  logic              rx_stb_i,
  input  logic              rx_flag_i,
  input  logic [HALF_W-1:0] rx_data_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o,
  output logic              rx_err_o
);
  dfl_tx #(.HALF_W(HALF_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tx_load_i),
    .word_i (tx_word_i),
    .data_o (link_data_o),
    .flag_o (link_flag_o),
    .stb_o  (link_stb_o)
  );

  dfl_rx #(.HALF_W(HALF_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stb_i   (rx_stb_i),
    .flag_i  (rx_flag_i),
    .data_i  (rx_data_i),
    .word_o  (rx_word_o),
    .valid_o (rx_valid_o),
    .err_o   (rx_err_o)
  );
endmodule

// File: rtl/dfl_link_checker.sv
module dfl_link_checker #(
  parameter int HALF_W = 20,
  localparam int WORD_W = 2 * HALF_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_load_i,
  input logic [WORD_W-1:0] tx_word_i,
  input logic [HALF_W-1:0] link_data_o,
  input logic              link_flag_o,
  input logic              link_stb_o,
  input logic              rx_stb_i,
  input logic              rx_flag_i,
  input logic [HALF_W-1:0] rx_data_i,
  input logic [WORD_W-1:0] rx_word_o,
  input logic              rx_valid_o,
  input logic              rx_err_o
);
  p_lo_from_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_stb_o && !link_flag_o) |->
      ($past(tx_load_i) && link_data_o == $past(tx_word_i[HALF_W-1:0])));

  p_hi_after_lo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_stb_o && !link_flag_o) |=> (link_stb_o && link_flag_o));

  p_hi_needs_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_stb_o && link_flag_o) |-> ($past(link_stb_o) && !$past(link_flag_o)));

  p_valid_from_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |->
      ($past(rx_stb_i && rx_flag_i) && rx_word_o[WORD_W-1:HALF_W] == $past(rx_data_i)));

  p_err_from_stb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_err_o |-> $past(rx_stb_i));

  p_valid_err_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_valid_o && rx_err_o));

  p_word_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_o |-> $stable(rx_word_o));

  p_no_strobe_no_event_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rx_stb_i) |-> (!rx_valid_o && !rx_err_o));
endmodule

bind dfl_link dfl_link_checker #(.HALF_W(HALF_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_load_i   (tx_load_i),
  .tx_word_i   (tx_word_i),
  .link_data_o (link_data_o),
  .link_flag_o (link_flag_o),
  .link_stb_o  (link_stb_o),
  .rx_stb_i    (rx_stb_i),
  .rx_flag_i   (rx_flag_i),
  .rx_data_i   (rx_data_i),
  .rx_word_o   (rx_word_o),
  .rx_valid_o  (rx_valid_o),
  .rx_err_o    (rx_err_o)
);

// File: tb/dfl_link_bench.sv
module dfl_link_bench;
  localparam int HW = 20;
  localparam int WW = 2 * HW;
  localparam int N_RAND = 300;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tx_load = 1'b0;
  logic [WW-1:0] tx_word = '0;
  logic [HW-1:0] link_data;
  logic          link_flag, link_stb;
  logic          loop = 1'b0;
  logic          b_stb = 1'b0, b_flag = 1'b0;
  logic [HW-1:0] b_data = '0;
  logic          rx_stb, rx_flag;
  logic [HW-1:0] rx_data;
  logic [WW-1:0] rx_word;
  logic          rx_valid, rx_err;

  int total = 0;
  int bad = 0;
  int matched = 0;
  logic [WW-1:0] exp_q[$];

  assign rx_stb  = loop ? link_stb  : b_stb;
  assign rx_flag = loop ? link_flag : b_flag;
  assign rx_data = loop ? link_data : b_data;

  always #4 clk = ~clk;

  dfl_link #(.HALF_W(HW)) u_dfl_link (
    .clk_i(clk), .rst_ni(rst_n), .tx_load_i(tx_load), .tx_word_i(tx_word),
    .link_data_o(link_data), .link_flag_o(link_flag), .link_stb_o(link_stb),
    .rx_stb_i(rx_stb), .rx_flag_i(rx_flag), .rx_data_i(rx_data),
    .rx_word_o(rx_word), .rx_valid_o(rx_valid), .rx_err_o(rx_err)
  );

  function automatic logic [HW-1:0] lo_of(logic [WW-1:0] w); return w[HW-1:0]; endfunction
  function automatic logic [HW-1:0] hi_of(logic [WW-1:0] w); return w[WW-1:HW]; endfunction
  function automatic logic [WW-1:0] join_w(logic [HW-1:0] h, logic [HW-1:0] l); return {h, l}; endfunction

  task automatic chk(string req, logic [WW-1:0] act, logic [WW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
    if (loop) begin
      if (rx_valid) begin
        if (exp_q.size() == 0) chk("R9 extra word", rx_word, '1);
        else begin
          chk("R9 loopback word", rx_word, exp_q.pop_front());
          matched++;
        end
      end
      if (rx_err) chk("R9 no error in loopback", {39'd0, rx_err}, '0);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; b_stb = 0; tx_load = 0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
  endtask

  task automatic rx_send(logic f, logic [HW-1:0] d);
    b_stb = 1'b1; b_flag = f; b_data = d;
    step();
    b_stb = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [WW-1:0] w1, w2, pw;
    void'($urandom(32'd1207));
    #3;
    // R1 during reset
    chk("R1 stb in reset", {39'd0, link_stb}, '0);
    chk("R1 word in reset", rx_word, '0);
    do_reset();
    step();
    chk("R1 outputs after reset", {link_stb, link_flag, link_data, rx_valid, rx_err}, '0);

    // R2 lone load
    w1 = 40'hA_BCDE_1234_5;
    tx_word = w1; tx_load = 1; step(); tx_load = 0;
    chk("R2 low half", {18'd0, link_stb, link_flag, link_data}, {18'd0, 1'b1, 1'b0, lo_of(w1)});
    step();
    chk("R2 high half", {18'd0, link_stb, link_flag, link_data}, {18'd0, 1'b1, 1'b1, hi_of(w1)});
    step();
    chk("R2 strobe drops", {39'd0, link_stb}, '0);

    // R3 load on low-half cycle ignored
    w1 = 40'h12_3456_789A; w2 = 40'hFF_FFFF_FFFF;
    tx_word = w1; tx_load = 1; step();
    tx_word = w2; step(); tx_load = 0;
    chk("R3 high half of first word", {20'd0, link_data}, {20'd0, hi_of(w1)});
    step();
    chk("R3 second load dropped", {39'd0, link_stb}, '0);

    // R5 leading highs after reset
    do_reset();
    rx_send(1'b1, 20'h11111);
    chk("R5 no event on leading high", {38'd0, rx_valid, rx_err}, '0);
    rx_send(1'b1, 20'h22222);
    chk("R5 still silent", {38'd0, rx_valid, rx_err}, '0);

    // R4 clean pair with gaps
    rx_send(1'b0, 20'hABCDE); step(); step();
    rx_send(1'b1, 20'h13579);
    chk("R4 valid", {39'd0, rx_valid}, 1);
    chk("R4 word", rx_word, join_w(20'h13579, 20'hABCDE));
    pw = rx_word;
    step();
    chk("R4 one-cycle pulse", {39'd0, rx_valid}, '0);
    chk("R8 word held", rx_word, pw);

    // R6 two lows
    rx_send(1'b0, 20'h00001);
    rx_send(1'b0, 20'h00002);
    chk("R6 error on repeated low", {38'd0, rx_valid, rx_err}, 40'd1);
    rx_send(1'b1, 20'h00003);
    chk("R6 second low kept", rx_word, join_w(20'h00003, 20'h00002));

    // R7 two highs
    rx_send(1'b1, 20'h00004);
    chk("R7 error on repeated high", {38'd0, rx_valid, rx_err}, 40'd1);
    chk("R8 word held across error", rx_word, join_w(20'h00003, 20'h00002));

    // R10 noise without strobe
    rx_send(1'b0, 20'h0AAAA);
    b_flag = 1'b0; b_data = 20'h0DEAD; step();
    b_flag = 1'b1; step();
    chk("R10 no event without strobe", {38'd0, rx_valid, rx_err}, '0);
    rx_send(1'b1, 20'h0BBBB);
    chk("R10 held low survives", rx_word, join_w(20'h0BBBB, 20'h0AAAA));

    // R9 random loopback
    do_reset();
    loop = 1'b1;
    for (int i = 0; i < N_RAND; i++) begin
      w1 = {$urandom, $urandom};
      if (i == 0) w1 = '0;
      if (i == 1) w1 = '1;
      exp_q.push_back(w1);
      tx_word = w1; tx_load = 1; step();
      tx_load = ($urandom % 4 == 0); // load on low-half cycle must be dropped
      tx_word = {$urandom, $urandom};
      step(); tx_load = 0;
      repeat ($urandom % 3) step();
    end
    repeat (4) step();
    chk("R9 all words delivered", matched, N_RAND);
    chk("R9 queue empty", exp_q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule